// File: doc/BRIEF.md
# Decomposed Large-Kernel Convolution Engine

This block computes one output value of a convolution filter. It does so on an array of identical units, each of which forms a 3x3 signed dot product. A filter of side K, from 1 to 9, is loaded as K*K weight/activation pairs. The block places them in a square buffer whose side is rounded up to the next multiple of 3. Every position beyond the K*K region holds zero, so a padded kernel breaks cleanly into ceil(K/3)^2 sub-kernels of 3x3. A kernel of side 3 or smaller is a single sub-kernel and occupies a single unit.

A sequencer hands out the sub-kernels to the units, up to NUM_UNITS per pass, and needs more than one pass only when the sub-kernels outnumber the units. Each unit registers its partial sum. An accumulator adds the partial sums of every pass, restarting from zero on the first pass of a filter, and reports the total with a one-cycle done pulse after the last pass. The array is never reconfigured, whatever the kernel size.

The caller pulses start with a kernel size while the engine is idle. It streams the pairs in row-major order while in_ready_o is high, and takes result_o when done_o rises.

Top module: `conv_decomp_engine`

## Requirements
- R1: A start_i pulse with k_size_i in 1..MAX_K, seen while busy_o is low, raises busy_o and in_ready_o from the next cycle.
- R2: A start_i pulse with k_size_i equal to 0 or above MAX_K is ignored, and busy_o stays low.
- R3: The load phase accepts exactly K*K beats (in_valid_i and in_ready_o high at a clock edge). Beat r*K+c carries row r and column c of the kernel and of the window. in_ready_o is low from the cycle after the last beat, and is never high while busy_o is low.
- R4: Padded positions outside the K*K region contribute zero. This holds even when the previous filter was larger and loaded nonzero data there.
- R5: result_o is the exact two's-complement sum, over all K*K beats, of the products of the 8-bit signed in_wt_i and in_act_i. This includes the extreme case of 81 products of -128 by -128.
- R6: The sub-kernels are issued in P = ceil(ceil(K/3)^2 / NUM_UNITS) passes, one pass per cycle. done_o is high in the cycle that follows the P+1-th clock edge after the edge that accepts the last beat.
- R7: done_o is high for exactly one cycle. busy_o is low in that same cycle. result_o keeps its value until the next done_o.
- R8: While busy_o is high, start_i and k_size_i have no effect: the kernel size of the running filter and its beat count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a filter (taken only while idle) |
| k_size_i | input | KW | Kernel side K, legal range 1..MAX_K |
| in_valid_i | input | 1 | Weight/activation beat valid |
| in_wt_i | input | DATA_W | Signed weight |
| in_act_i | input | DATA_W | Signed activation |
| in_ready_o | output | 1 | Load phase active, beat accepted when valid |
| busy_o | output | 1 | Filter in progress |
| done_o | output | 1 | One-cycle pulse, result_o updated |
| result_o | output | ACC_W | Signed filter result |

## Verification
The assertions assume that rst_ni is applied before the first start and that any start_i is a valid request whose k_size_i is settled in the cycle it is sampled. The result bound also assumes that the result only ever sums products of in-range 8-bit operands, at most MAX_K*MAX_K of them. The stimulus changes inputs only on the falling clock edge. It asserts in_valid_i only while in_ready_o is high and never skips a beat. It deliberately raises start_i with a different or illegal kernel size during load or while idle, which is how the ignore rules are exercised. The bench sweeps every kernel size from 1 to 9 under several operand patterns, including both product extremes, on an instance with two units, so that larger kernels take up to five passes.

// File: rtl/conv_decomp_pkg.sv
package conv_decomp_pkg;
  localparam int SUB = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_DRAIN
  } seq_state_e;

  function automatic int tiles_of(input int k);
    return (k + SUB - 1) / SUB;
  endfunction
endpackage

// File: rtl/conv_pad_buf.sv
module conv_pad_buf #(
  parameter int PAD_K  = 9,
  parameter int DATA_W = 8,
  parameter int KW     = 4,
  localparam int MEM_N = PAD_K * PAD_K
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_i,
  input  logic [KW-1:0]            k_i,
  input  logic signed [DATA_W-1:0] wt_i,
  input  logic signed [DATA_W-1:0] act_i,
  output logic                     last_beat_o,
  output logic signed [DATA_W-1:0] wt_mem_o  [MEM_N],
  output logic signed [DATA_W-1:0] act_mem_o [MEM_N]
);
  logic [KW-1:0] row_q, col_q;
  int wr_idx;

  assign wr_idx      = int'(row_q) * PAD_K + int'(col_q);
  assign last_beat_o = (row_q == k_i - 1'b1) && (col_q == k_i - 1'b1);

  // clear on every accepted start: zero padding and no stale data from a larger filter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      for (int i = 0; i < MEM_N; i++) begin
        wt_mem_o[i]  <= '0;
        act_mem_o[i] <= '0;
      end
    end else if (clr_i) begin
      row_q <= '0;
      col_q <= '0;
      for (int i = 0; i < MEM_N; i++) begin
        wt_mem_o[i]  <= '0;
        act_mem_o[i] <= '0;
      end
    end else if (wr_i) begin
      if (wr_idx < MEM_N) begin
        wt_mem_o[wr_idx]  <= wt_i;
        act_mem_o[wr_idx] <= act_i;
      end
      if (col_q == k_i - 1'b1) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_sub_seq.sv
module conv_sub_seq
  import conv_decomp_pkg::*;
#(
  parameter int NUM_UNITS = 16,
  parameter int MAX_K     = 9,
  parameter int KW        = 4,
  parameter int PW        = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [KW-1:0] k_size_i,
  input  logic          last_wr_i,
  input  logic          fin_i,
  output logic          busy_o,
  output logic          ready_o,
  output logic          clr_o,
  output logic          issue_o,
  output logic          first_o,
  output logic          last_o,
  output logic [PW-1:0] pass_o,
  output logic [KW-1:0] k_o
);
  seq_state_e state_q;
  logic [KW-1:0] k_q;
  logic [PW-1:0] pass_q;
  logic legal, accept;
  int n_pass;

  assign legal  = (k_size_i != '0) && (int'(k_size_i) <= MAX_K);
  assign accept = (state_q == ST_IDLE) && start_i && legal;

  always_comb begin
    int t;
    t      = tiles_of(int'(k_q));
    n_pass = (t * t + NUM_UNITS - 1) / NUM_UNITS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      pass_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          k_q     <= k_size_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (last_wr_i) begin
          pass_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (int'(pass_q) >= n_pass - 1) state_q <= ST_DRAIN;
          else pass_q <= pass_q + 1'b1;
        end
        ST_DRAIN: if (fin_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_LOAD);
  assign clr_o   = accept;
  assign issue_o = (state_q == ST_RUN);
  assign first_o = (pass_q == '0);
  assign last_o  = (int'(pass_q) >= n_pass - 1);
  assign pass_o  = pass_q;
  assign k_o     = k_q;
endmodule

// File: rtl/conv_dot3x3.sv
module conv_dot3x3 #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24,
  parameter int TAPS   = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] wt_i  [TAPS],
  input  logic signed [DATA_W-1:0] act_i [TAPS],
  output logic signed [ACC_W-1:0]  sum_o
);
  localparam int PROD_W = 2 * DATA_W;
  logic signed [ACC_W-1:0] sum_d;

  always_comb begin
    logic signed [PROD_W-1:0] p;
    sum_d = '0;
    for (int t = 0; t < TAPS; t++) begin
      p     = wt_i[t] * act_i[t];
      sum_d = sum_d + {{(ACC_W-PROD_W){p[PROD_W-1]}}, p};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_o <= '0;
    else if (en_i) sum_o <= sum_d;
    else           sum_o <= '0;
  end
endmodule

// File: rtl/conv_psum_acc.sv
module conv_psum_acc #(
  parameter int NUM_UNITS = 16,
  parameter int ACC_W     = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    issue_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic signed [ACC_W-1:0] unit_sum_i [NUM_UNITS],
  output logic                    fin_o,
  output logic                    done_o,
  output logic [ACC_W-1:0]        result_o
);
  // tags travel alongside the registered unit sums
  logic vld_q, first_q, last_q;
  logic signed [ACC_W-1:0] acc_q, total, acc_d;

  always_comb begin
    total = '0;
    for (int u = 0; u < NUM_UNITS; u++) total = total + unit_sum_i[u];
    acc_d = (first_q ? '0 : acc_q) + total;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= 1'b0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      acc_q    <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      vld_q   <= issue_i;
      first_q <= first_i;
      last_q  <= last_i;
      done_o  <= vld_q && last_q;
      if (vld_q) acc_q <= acc_d;
      if (vld_q && last_q) result_o <= acc_d;
    end
  end

  assign fin_o = vld_q && last_q;
endmodule

// File: rtl/conv_decomp_engine.sv
module conv_decomp_engine
  import conv_decomp_pkg::*;
#(
  parameter int NUM_UNITS = 16,
  parameter int MAX_K     = 9,
  parameter int DATA_W    = 8,
  parameter int ACC_W     = 24,
  localparam int KW       = $clog2(MAX_K + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KW-1:0]     k_size_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_wt_i,
  input  logic [DATA_W-1:0] in_act_i,
  output logic              in_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ACC_W-1:0]  result_o
);
  localparam int MAX_T    = (MAX_K + SUB - 1) / SUB;
  localparam int PAD_K    = MAX_T * SUB;
  localparam int MEM_N    = PAD_K * PAD_K;
  localparam int TAPS     = SUB * SUB;
  localparam int MAX_PASS = (MAX_T * MAX_T + NUM_UNITS - 1) / NUM_UNITS;
  localparam int PW       = (MAX_PASS > 1) ? $clog2(MAX_PASS) : 1;

  logic wr, buf_last, clr, issue, first, last, fin;
  logic [PW-1:0] pass_q;
  logic [KW-1:0] k_q;
  logic signed [DATA_W-1:0] wt_mem  [MEM_N];
  logic signed [DATA_W-1:0] act_mem [MEM_N];
  logic signed [DATA_W-1:0] u_wt  [NUM_UNITS][TAPS];
  logic signed [DATA_W-1:0] u_act [NUM_UNITS][TAPS];
  logic                     u_en  [NUM_UNITS];
  logic signed [ACC_W-1:0]  u_sum [NUM_UNITS];

  assign wr = in_valid_i && in_ready_o;

  conv_sub_seq #(
    .NUM_UNITS(NUM_UNITS), .MAX_K(MAX_K), .KW(KW), .PW(PW)
  ) seq_i (
    .clk_i, .rst_ni, .start_i, .k_size_i,
    .last_wr_i(wr && buf_last),
    .fin_i    (fin),
    .busy_o   (busy_o),
    .ready_o  (in_ready_o),
    .clr_o    (clr),
    .issue_o  (issue),
    .first_o  (first),
    .last_o   (last),
    .pass_o   (pass_q),
    .k_o      (k_q)
  );

  conv_pad_buf #(
    .PAD_K(PAD_K), .DATA_W(DATA_W), .KW(KW)
  ) buf_i (
    .clk_i, .rst_ni,
    .clr_i      (clr),
    .wr_i       (wr),
    .k_i        (k_q),
    .wt_i       (in_wt_i),
    .act_i      (in_act_i),
    .last_beat_o(buf_last),
    .wt_mem_o   (wt_mem),
    .act_mem_o  (act_mem)
  );

  // unit u takes sub-kernel pass*NUM_UNITS+u, sub-kernels ordered row-major over tiles
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_comb begin
      int j, t, sr, sc, idx;
      j  = int'(pass_q) * NUM_UNITS + u;
      t  = tiles_of(int'(k_q));
      u_en[u] = issue && (j < t * t);
      sr = 0;
      sc = 0;
      if (u_en[u]) begin
        sr = j / t;
        sc = j % t;
      end
      for (int r = 0; r < SUB; r++) begin
        for (int c = 0; c < SUB; c++) begin
          idx = (sr * SUB + r) * PAD_K + sc * SUB + c;
          if (idx < MEM_N) begin
            u_wt[u][r*SUB+c]  = wt_mem[idx];
            u_act[u][r*SUB+c] = act_mem[idx];
          end else begin
            u_wt[u][r*SUB+c]  = '0;
            u_act[u][r*SUB+c] = '0;
          end
        end
      end
    end

    conv_dot3x3 #(
      .DATA_W(DATA_W), .ACC_W(ACC_W), .TAPS(TAPS)
    ) dot_i (
      .clk_i, .rst_ni,
      .en_i (u_en[u]),
      .wt_i (u_wt[u]),
      .act_i(u_act[u]),
      .sum_o(u_sum[u])
    );
  end

  conv_psum_acc #(
    .NUM_UNITS(NUM_UNITS), .ACC_W(ACC_W)
  ) acc_i (
    .clk_i, .rst_ni,
    .issue_i   (issue),
    .first_i   (first),
    .last_i    (last),
    .unit_sum_i(u_sum),
    .fin_o     (fin),
    .done_o    (done_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/conv_decomp_engine_chk.sv
module conv_decomp_engine_chk #(
  parameter int MAX_K  = 9,
  parameter int KW     = 4,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [KW-1:0]    k_size_i,
  input logic             busy_o,
  input logic             in_ready_o,
  input logic             done_o,
  input logic [ACC_W-1:0] result_o,
  input logic [KW-1:0]    cfg_k
);
  localparam int LIM = MAX_K * MAX_K * (2 ** (2 * DATA_W - 2));

  logic legal;
  assign legal = (k_size_i != '0) && (int'(k_size_i) <= MAX_K);

  assert_start_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && legal) |=> (busy_o && in_ready_o));

  assert_illegal_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !legal) |=> !busy_o);

  assert_ready_in_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> busy_o);

  assert_result_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((int'($signed(result_o)) <= LIM) && (int'($signed(result_o)) >= -LIM)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && $past(rst_ni)) |-> $stable(result_o));

  assert_k_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cfg_k));
endmodule

bind conv_decomp_engine conv_decomp_engine_chk #(
  .MAX_K(MAX_K), .KW(KW), .DATA_W(DATA_W), .ACC_W(ACC_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .k_size_i  (k_size_i),
  .busy_o    (busy_o),
  .in_ready_o(in_ready_o),
  .done_o    (done_o),
  .result_o  (result_o),
  .cfg_k     (k_q)
);

// File: tb/conv_decomp_engine_tb_top.sv
module conv_decomp_engine_tb_top;
  localparam int U      = 2;
  localparam int MAX_K  = 9;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 24;
  localparam int KW     = $clog2(MAX_K + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] ksz = '0;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] wt = '0, act = '0;
  logic in_ready, busy, done;
  logic [ACC_W-1:0] result;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  conv_decomp_engine #(
    .NUM_UNITS(U), .MAX_K(MAX_K), .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .k_size_i(ksz),
    .in_valid_i(in_valid), .in_wt_i(wt), .in_act_i(act),
    .in_ready_o(in_ready), .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int actual, input int expect_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expect_v);
    end
  endtask

  function automatic int gen_w(input int p, input int k, input int i);
    case (p)
      0: return 1;
      1: return ((i * 37 + k * 11 + 5) % 256) - 128;
      2: return -128;
      default: return 127;
    endcase
  endfunction

  function automatic int gen_a(input int p, input int k, input int i);
    case (p)
      0: return i - 40;
      1: return ((i * 53 + k * 7 + 17) % 256) - 128;
      default: return -128;
    endcase
  endfunction

  task automatic run_filter(input int k, input int p, input bit interfere);
    int expect_sum = 0;
    int t, npass, cyc;
    bit ready_ok = 1'b1;
    logic [ACC_W-1:0] held;
    t     = (k + 2) / 3;
    npass = (t * t + U - 1) / U;
    @(negedge clk);
    start = 1'b1;
    ksz   = KW'(k);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    chk(in_ready == 1'b1, "R1 ready after start", int'(in_ready), 1);
    for (int i = 0; i < k * k; i++) begin
      if (!in_ready) ready_ok = 1'b0;
      if (interfere && i >= 2) begin
        start = (i == 2);
        ksz   = KW'(MAX_K);
      end
      in_valid = 1'b1;
      wt  = DATA_W'(gen_w(p, k, i));
      act = DATA_W'(gen_a(p, k, i));
      expect_sum += gen_w(p, k, i) * gen_a(p, k, i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    start    = 1'b0;
    chk(ready_ok, "R3 ready through load", int'(ready_ok), 1);
    chk(in_ready == 1'b0, interfere ? "R8 beat count unchanged" : "R3 ready drops after K*K beats",
        int'(in_ready), 0);
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == npass + 1, "R6 latency", cyc, npass + 1);
    chk(int'($signed(result)) == expect_sum, interfere ? "R8 result of running size" : "R5 R4 result",
        int'($signed(result)), expect_sum);
    chk(busy == 1'b0, "R7 idle at done", int'(busy), 0);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
    @(negedge clk);
    chk(result == held, "R7 result held", int'($signed(result)), int'($signed(held)));
  endtask

  task automatic try_illegal(input int k);
    @(negedge clk);
    start = 1'b1;
    ksz   = KW'(k);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R2 illegal size ignored", int'(busy), 0);
    @(negedge clk);
    chk(in_ready == 1'b0, "R2 no load for illegal size", int'(in_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(done == 1'b0, "R7 reset done", int'(done), 0);
    chk(in_ready == 1'b0, "R3 reset ready", int'(in_ready), 0);
    chk(result == '0, "R5 reset result", int'(result), 0);

    try_illegal(0);
    try_illegal(10);
    try_illegal(15);

    // descending sizes: each filter follows a larger one, stale data must not leak (R4)
    for (int k = MAX_K; k >= 1; k--) run_filter(k, 1, 1'b0);
    for (int p = 0; p < 4; p++) begin
      for (int k = 1; k <= MAX_K; k++) run_filter(k, p, 1'b0);
    end

    run_filter(3, 1, 1'b1);
    run_filter(5, 2, 1'b1);
    try_illegal(12);
    run_filter(9, 2, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule